// File: doc/BRIEF.md
# UART Power-Down and Status Controller

This block sequences a serial port into and out of a low-power sleep state and derives the status and interrupt flags that go with it. A host configuration write carries a sleep request bit and a transmit-interrupt mask bit. Both are held pending and take effect only when the host signals the end of its access with a chip-select release event. A software sleep request first lets the transmitter drain. The baud oscillator enable is removed only once the transmitter reports idle. A dedicated hardware sleep pin bypasses this and forces sleep at once.

On every entry into sleep the block emits a one-cycle clear pulse. The neighbouring data, parity and flag registers and the receive FIFO use it to wipe their contents. While asleep the block watches the receive line and latches any transition as receiver activity. When a write with the sleep bit at 0 takes effect and the hardware pin is low, the oscillator enable returns. A ready-to-run indication then stays low for a programmable restart delay (`WAKE_CYCLES`). Modem-control state is outside this block and is never touched by it.

The block has no data path, so it has no streaming valid/ready interface and no back-pressure: every port is a plain control or status level, or a single-cycle event strobe.

Top module: `uart_pwr_ctl`

## Requirements
- R1: After reset, osc_en = 1, run_ready = 1, and clr_pulse, sleep_rb, rx_act and irq are all 0; the stored mask and sleep request are both 0.
- R2: cfg_wr stores cfg_sleep and cfg_txmask as pending values only. They become active at the clock edge that samples cs_rise = 1, and the values written in that same cycle win. A write with no cs_rise changes no output.
- R3: When an active sleep request meets a busy transmitter (tx_idle = 0), run_ready falls one cycle after the request becomes active. Meanwhile osc_en stays 1 and sleep_rb stays 0 for as long as tx_idle stays 0.
- R4: While draining, the first edge that samples tx_idle = 1 enters sleep: osc_en becomes 0 and sleep_rb becomes 1 after that edge.
- R5: clr_pulse is 1 for exactly one cycle, namely the first cycle of each entry into sleep, whether software or the hardware pin caused the entry.
- R6: hw_sleep = 1 makes sleep_rb = 1 and osc_en = 0 combinationally in the same cycle, and the block sleeps for as long as the pin is high. When the pin drops, the block wakes if the active sleep request is 0 and stays asleep if it is 1.
- R7: rx_act is set by any change of rx_line sampled while asleep. A change outside sleep never sets it. It is cleared to 0 on entry into sleep, in the same cycle as clr_pulse, and is otherwise held.
- R8: When an active sleep request of 0 meets sleep with hw_sleep = 0, osc_en returns to 1 at the next edge. run_ready then stays 0 for exactly WAKE_CYCLES cycles before it returns to 1.
- R9: irq equals the active mask bit ANDed with tx_idle, and follows tx_idle combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sleep | input | 1 | Sleep request bit carried by the write |
| cfg_txmask | input | 1 | Transmit-empty interrupt mask bit carried by the write |
| cs_rise | input | 1 | Chip-select release event, one cycle |
| hw_sleep | input | 1 | Hardware sleep pin, active high |
| tx_idle | input | 1 | Transmitter idle / transmit buffer empty |
| rx_line | input | 1 | Serial receive line |
| osc_en | output | 1 | Baud oscillator enable |
| run_ready | output | 1 | Oscillator settled and block running |
| clr_pulse | output | 1 | One-cycle clear for data, parity and flag registers and the receive FIFO |
| sleep_rb | output | 1 | Sleep read-back bit |
| rx_act | output | 1 | Receive activity seen while asleep |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
The bench holds a write pending without a chip-select event. A design that applied writes immediately would raise irq or start draining too early. It requests sleep while the transmitter is busy, which catches a design that drops the oscillator or raises the read-back before the drain ends. It toggles the receive line both awake and asleep, and sleeps again through the pin, which exposes an activity bit that is set outside sleep or not cleared on re-entry. It counts the cycles of low run_ready after each wake, and it releases the pin while a software request is still active, which catches an off-by-one restart delay or a pin release that wakes the port against the software request.

// File: rtl/uart_pwr_pkg.sv
package uart_pwr_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_DRAIN = 2'd1,
    PS_SLEEP = 2'd2,
    PS_WAKE  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/uart_pwr_cfg.sv
// Holds configuration bits pending until chip-select release.
module uart_pwr_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_sleep,
  input  logic cfg_txmask,
  input  logic cs_rise,
  output logic sleep_req,
  output logic txmask
);
  logic pend_vld, pend_sleep, pend_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld   <= 1'b0;
      pend_sleep <= 1'b0;
      pend_mask  <= 1'b0;
      sleep_req  <= 1'b0;
      txmask     <= 1'b0;
    end else if (cs_rise) begin
      pend_vld <= 1'b0;
      if (cfg_wr) begin
        sleep_req <= cfg_sleep;
        txmask    <= cfg_txmask;
      end else if (pend_vld) begin
        sleep_req <= pend_sleep;
        txmask    <= pend_mask;
      end
    end else if (cfg_wr) begin
      pend_vld   <= 1'b1;
      pend_sleep <= cfg_sleep;
      pend_mask  <= cfg_txmask;
    end
  end
endmodule

// File: rtl/uart_pwr_fsm.sv
// Sleep sequencing state machine with restart-delay counter.
module uart_pwr_fsm
  import uart_pwr_pkg::*;
#(
  parameter int WAKE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic hw_sleep,
  input  logic tx_idle,
  output logic asleep,
  output logic running,
  output logic enter_sleep,
  output logic clr_pulse
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

  pwr_state_e st_q, st_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_RUN:   if (sleep_req) st_d = PS_DRAIN;
      PS_DRAIN: if (!sleep_req) st_d = PS_RUN;
                else if (tx_idle) st_d = PS_SLEEP;
      PS_SLEEP: if (!sleep_req && !hw_sleep) st_d = PS_WAKE;
      PS_WAKE:  if (sleep_req) st_d = PS_DRAIN;
                else if (cnt_q == LAST) st_d = PS_RUN;
      default:  st_d = PS_RUN;
    endcase
    if (hw_sleep) st_d = PS_SLEEP;
  end

  assign enter_sleep = (st_d == PS_SLEEP) && (st_q != PS_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= PS_RUN;
      cnt_q     <= '0;
      clr_pulse <= 1'b0;
    end else begin
      st_q      <= st_d;
      clr_pulse <= enter_sleep;
      if (st_q == PS_WAKE && st_d == PS_WAKE) cnt_q <= cnt_q + 1'b1;
      else                                    cnt_q <= '0;
    end
  end

  assign asleep  = (st_q == PS_SLEEP);
  assign running = (st_q == PS_RUN);
endmodule

// File: rtl/uart_pwr_rxact.sv
// Latches receive-line activity seen while asleep.
module uart_pwr_rxact (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic asleep,
  input  logic enter_sleep,
  output logic rx_act
);
  logic rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= 1'b1;
      rx_act <= 1'b0;
    end else begin
      rx_q <= rx_line;
      if (enter_sleep)                    rx_act <= 1'b0;
      else if (asleep && (rx_line != rx_q)) rx_act <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_pwr_ctl.sv
// Top: UART shutdown and status controller.
module uart_pwr_ctl #(
  parameter int WAKE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_sleep,
  input  logic cfg_txmask,
  input  logic cs_rise,
  input  logic hw_sleep,
  input  logic tx_idle,
  input  logic rx_line,
  output logic osc_en,
  output logic run_ready,
  output logic clr_pulse,
  output logic sleep_rb,
  output logic rx_act,
  output logic irq
);
  logic sleep_req, txmask, asleep, running, enter_sleep;

  uart_pwr_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sleep(cfg_sleep),
    .cfg_txmask(cfg_txmask), .cs_rise(cs_rise),
    .sleep_req(sleep_req), .txmask(txmask)
  );

  uart_pwr_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .hw_sleep(hw_sleep),
    .tx_idle(tx_idle), .asleep(asleep), .running(running),
    .enter_sleep(enter_sleep), .clr_pulse(clr_pulse)
  );

  uart_pwr_rxact u_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .asleep(asleep),
    .enter_sleep(enter_sleep), .rx_act(rx_act)
  );

  assign osc_en    = !asleep && !hw_sleep;
  assign run_ready = running && !hw_sleep;
  assign sleep_rb  = asleep || hw_sleep;
  assign irq       = txmask && tx_idle;
endmodule

// File: rtl/uart_pwr_ctl_chk.sv
// Property checker bound to the top module.
module uart_pwr_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic hw_sleep,
  input logic tx_idle,
  input logic osc_en,
  input logic run_ready,
  input logic clr_pulse,
  input logic sleep_rb,
  input logic rx_act,
  input logic irq
);
  p_clr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
  p_clr_in_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> sleep_rb);
  p_hw_forces_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_sleep |-> (sleep_rb && !osc_en));
  p_sleep_no_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_rb |-> !osc_en);
  p_drain_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sleep_rb) && !hw_sleep) |-> $past(tx_idle));
  p_act_only_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_act)) |-> $past(sleep_rb));
  p_ready_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_ready |-> osc_en);
  p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tx_idle);
endmodule

bind uart_pwr_ctl uart_pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_sleep(hw_sleep), .tx_idle(tx_idle),
  .osc_en(osc_en), .run_ready(run_ready), .clr_pulse(clr_pulse),
  .sleep_rb(sleep_rb), .rx_act(rx_act), .irq(irq)
);

// File: tb/sim_uart_pwr_ctl.sv
module sim_uart_pwr_ctl;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_sleep = 1'b0, cfg_txmask = 1'b0, cs_rise = 1'b0;
  logic hw_sleep = 1'b0, tx_idle = 1'b1, rx_line = 1'b1;
  logic osc_en, run_ready, clr_pulse, sleep_rb, rx_act, irq;

  always #2.5 clk = ~clk;

  uart_pwr_ctl #(.WAKE_CYCLES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sleep(cfg_sleep),
    .cfg_txmask(cfg_txmask), .cs_rise(cs_rise), .hw_sleep(hw_sleep),
    .tx_idle(tx_idle), .rx_line(rx_line), .osc_en(osc_en),
    .run_ready(run_ready), .clr_pulse(clr_pulse), .sleep_rb(sleep_rb),
    .rx_act(rx_act), .irq(irq)
  );

  // expected vector: {osc_en, run_ready, clr_pulse, sleep_rb, rx_act, irq}
  typedef struct {
    int         cyc;
    string      tag;
    logic [5:0] exp;
  } exp_t;

  exp_t sb_q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [5:0] outs();
    return {osc_en, run_ready, clr_pulse, sleep_rb, rx_act, irq};
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (osc,rdy,clr,rb,act,irq)", tag, act, exp);
    end
  endtask

  // driver: inputs already set at a negedge; expect result after next edge
  task automatic step(string tag, logic [5:0] exp);
    exp_t e;
    e.cyc = cyc + 1;
    e.tag = tag;
    e.exp = exp;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compares queued expectations shortly after each edge
  always @(posedge clk) begin
    cyc++;
    #1;
    while (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, outs(), e.exp);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1 reset state", 6'b110000);

    // R2: write mask=1 with no cs release: nothing changes
    cfg_wr = 1; cfg_txmask = 1; cfg_sleep = 0;
    step("R2 pending write", 6'b110000);
    cfg_wr = 0;
    step("R2 still pending", 6'b110000);
    cs_rise = 1;
    step("R9 mask applied at cs release", 6'b110001);
    cs_rise = 0;
    tx_idle = 0;
    step("R9 irq follows tx_idle low", 6'b110000);
    tx_idle = 1;
    step("R9 irq follows tx_idle high", 6'b110001);

    // R7: rx activity while awake is ignored
    rx_line = 0;
    step("R7 rx toggle awake", 6'b110001);
    rx_line = 1;
    step("R7 rx toggle awake", 6'b110001);

    // R3: sleep request with busy transmitter
    cfg_wr = 1; cfg_sleep = 1; cfg_txmask = 0; tx_idle = 0;
    step("R2 sleep write pending", 6'b110000);
    cfg_wr = 0;
    step("R2 sleep write still pending", 6'b110000);
    cs_rise = 1;
    step("R3 request active", 6'b110000);
    cs_rise = 0;
    step("R3 draining", 6'b100000);
    step("R3 draining hold", 6'b100000);
    step("R3 draining hold", 6'b100000);

    // R4/R5: transmitter drains
    tx_idle = 1;
    step("R4 R5 enter sleep", 6'b001100);
    step("R5 clear is one cycle", 6'b000100);
    step("R7 quiet line asleep", 6'b000100);
    rx_line = 0;
    step("R7 rx toggle asleep", 6'b000110);
    rx_line = 1;
    step("R7 activity held", 6'b000110);

    // R8: wake via write + cs release in same cycle
    cfg_wr = 1; cfg_sleep = 0; cs_rise = 1;
    step("R2 R8 wake request active", 6'b000110);
    cfg_wr = 0; cs_rise = 0;
    step("R8 osc back, not ready", 6'b100010);
    for (int i = 0; i < W - 1; i++) step("R8 restart delay", 6'b100010);
    step("R8 ready after delay", 6'b110010);

    // R6: hardware pin forces sleep at once
    hw_sleep = 1;
    #1;
    check("R6 immediate read-back", {sleep_rb, osc_en}, 2'b10);
    step("R6 R5 R7 pin sleep, clear, activity wiped", 6'b001100);
    step("R6 pin held", 6'b000100);
    hw_sleep = 0;
    step("R6 pin release wakes", 6'b100000);
    for (int i = 0; i < W - 1; i++) step("R8 restart delay after pin", 6'b100000);
    step("R8 ready after pin wake", 6'b110000);

    // R6: pin release with software request still active
    cfg_wr = 1; cfg_sleep = 1; cs_rise = 1; tx_idle = 0;
    step("R3 request active again", 6'b110000);
    cfg_wr = 0; cs_rise = 0;
    step("R3 draining again", 6'b100000);
    hw_sleep = 1;
    #1;
    check("R6 immediate during drain", {sleep_rb, osc_en}, 2'b10);
    step("R6 pin sleep from drain", 6'b001100);
    hw_sleep = 0;
    step("R6 release keeps sleep", 6'b000100);
    step("R6 release keeps sleep hold", 6'b000100);

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule